// File: doc/BRIEF.md
# Warp Lane Shuffle Unit

This block swaps one 32-bit word per lane among the 32 lanes of a warp in a single registered step. Each lane supplies a value. One operation code, one 5-bit operand and one segment width apply to the whole warp. A lane can fetch the value held by another lane in the same segment. Bits move unchanged, so integer and floating-point data are handled the same way.

The segment width splits the warp into equal groups that shuffle independently. In indexed mode, every lane in a group reads one chosen offset within that group, which makes it a broadcast. In up and down modes, a lane reads from a lane a fixed distance below or above it. These modes never wrap: a lane whose source would fall outside its group keeps its own value. In xor mode, a lane pairs with the lane whose in-group index differs by the operand bits, which gives a butterfly exchange. A lane whose chosen source is switched off in the active mask keeps its own value. The results appear on the clock edge that follows a valid request.

Top module: `warp_shuffle_unit`

## Requirements
- R1: While reset is asserted, `out_valid_o` is low and every result lane reads zero.
- R2: `out_valid_o` is high in the cycle after `in_valid_i` is high, and low in the cycle after it is low.
- R3: With `op_i` = 0 (indexed), every lane receives the value of the lane at position `operand_i` mod W within its own group of W lanes. For example, W=16 and operand 3 give lane 3 to lanes 0..15 and lane 19 to lanes 16..31.
- R4: With `op_i` = 1 (up), lane i receives lane i-d, where d is the operand. When the in-group offset of i is less than d, the lane keeps its own value.
- R5: With `op_i` = 2 (down), lane i receives lane i+d. When the in-group offset plus d exceeds W-1, the lane keeps its own value.
- R6: With `op_i` = 3 (xor), lane i receives the lane in its group whose offset is (offset XOR operand) mod W. Mask 1 swaps each even lane with the next odd lane.
- R7: When the selected source lane has its `act_mask_i` bit (bit n for lane n) at zero, the destination lane receives its own input value.
- R8: `width_i` takes the group size directly (2, 4, 8, 16 or 32). Any other value is treated as 32.
- R9: A cycle without `in_valid_i` leaves `result_o` unchanged, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request valid |
| lanes_i | input | 1024 | Lane values; lane n occupies bits [32n+31:32n] |
| act_mask_i | input | 32 | Active lanes, bit n for lane n |
| op_i | input | 2 | 0 indexed, 1 up, 2 down, 3 xor |
| operand_i | input | 5 | Source offset, distance or xor mask |
| width_i | input | 6 | Group size |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 1024 | Shuffled lanes, same layout as `lanes_i` |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing;
- that the result holds while no request is given;
- identity results for xor with mask 0, for up with distance 0, and for an all-inactive mask.

The following can only be shown by the bench scenarios, which compare each result against a lane-by-lane model:
- the group-relative source choice across widths;
- the no-wrap edges at each group boundary in up and down;
- the butterfly pairing;
- the inactive-source fallback;
- the treatment of illegal widths.

// File: rtl/shfl_pkg.sv
package shfl_pkg;
  typedef enum logic [1:0] {
    SHFL_IDX  = 2'd0,
    SHFL_UP   = 2'd1,
    SHFL_DOWN = 2'd2,
    SHFL_XOR  = 2'd3
  } shfl_op_e;
endpackage

// File: rtl/shfl_width_decode.sv
module shfl_width_decode #(
  parameter int LIDX_W = 5
) (
  input  logic [LIDX_W:0]   width_i,
  output logic [LIDX_W-1:0] grp_mask_o
);
  localparam int WSW = LIDX_W + 1;

  // Legal group sizes are powers of two from 2 up to the full warp.
  // Anything else falls back to the whole warp.
  always_comb begin
    grp_mask_o = '1;
    for (int k = 1; k <= LIDX_W; k++) begin
      if (width_i == WSW'(1 << k)) grp_mask_o = LIDX_W'((1 << k) - 1);
    end
  end
endmodule

// File: rtl/shfl_lane_route.sv
module shfl_lane_route
  import shfl_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int LANE   = 0,
  parameter int LIDX_W = $clog2(LANES)
) (
  input  shfl_op_e          op_i,
  input  logic [LIDX_W-1:0] operand_i,
  input  logic [LIDX_W-1:0] grp_mask_i,
  input  logic [LANES-1:0]  active_i,
  output logic [LIDX_W-1:0] src_o,
  output logic              self_o
);
  localparam logic [LIDX_W-1:0] ME = LIDX_W'(LANE);

  logic [LIDX_W-1:0] offs, base, cand;
  logic [LIDX_W:0]   reach;
  logic              outside;

  always_comb begin
    offs    = ME & grp_mask_i;
    base    = ME & ~grp_mask_i;
    reach   = {1'b0, offs} + {1'b0, operand_i};
    outside = 1'b0;
    cand    = ME;
    unique case (op_i)
      SHFL_IDX: cand = base | (operand_i & grp_mask_i);
      SHFL_XOR: cand = base | ((offs ^ operand_i) & grp_mask_i);
      SHFL_UP: begin
        outside = operand_i > offs;
        cand    = ME - operand_i;
      end
      SHFL_DOWN: begin
        outside = reach > {1'b0, grp_mask_i};
        cand    = ME + operand_i;
      end
      default: cand = ME;
    endcase
    src_o  = cand;
    self_o = outside | ~active_i[cand];
  end
endmodule

// File: rtl/shfl_xbar.sv
module shfl_xbar #(
  parameter int LANES  = 32,
  parameter int DW     = 32,
  parameter int LIDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0][DW-1:0]     data_i,
  input  logic [LANES-1:0][LIDX_W-1:0] src_i,
  input  logic [LANES-1:0]             self_i,
  output logic [LANES-1:0][DW-1:0]     data_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_col
    always_comb begin
      data_o[g] = self_i[g] ? data_i[g] : data_i[src_i[g]];
    end
  end
endmodule

// File: rtl/warp_shuffle_unit.sv
module warp_shuffle_unit
  import shfl_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 32,
  localparam int LIDX_W = $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid_i,
  input  logic [LANES*DW-1:0]   lanes_i,
  input  logic [LANES-1:0]      act_mask_i,
  input  logic [1:0]            op_i,
  input  logic [LIDX_W-1:0]     operand_i,
  input  logic [LIDX_W:0]       width_i,
  output logic                  out_valid_o,
  output logic [LANES*DW-1:0]   result_o
);
  logic [LIDX_W-1:0]             grp_mask;
  logic [LANES-1:0][DW-1:0]      lanes_v, routed;
  logic [LANES-1:0][LIDX_W-1:0]  src_sel;
  logic [LANES-1:0]              keep_own;
  logic [LANES*DW-1:0]           res_d, res_q;
  logic                          vld_d, vld_q;
  shfl_op_e                      op_e;

  assign op_e    = shfl_op_e'(op_i);
  assign lanes_v = lanes_i;

  shfl_width_decode #(.LIDX_W(LIDX_W)) u_wdec (
    .width_i    (width_i),
    .grp_mask_o (grp_mask)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_route
    shfl_lane_route #(.LANES(LANES), .LANE(l)) u_route (
      .op_i       (op_e),
      .operand_i  (operand_i),
      .grp_mask_i (grp_mask),
      .active_i   (act_mask_i),
      .src_o      (src_sel[l]),
      .self_o     (keep_own[l])
    );
  end

  shfl_xbar #(.LANES(LANES), .DW(DW)) u_xbar (
    .data_i (lanes_v),
    .src_i  (src_sel),
    .self_i (keep_own),
    .data_o (routed)
  );

  always_comb begin
    vld_d = in_valid_i;
    res_d = res_q;
    if (in_valid_i) res_d = routed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid_o = vld_q;
  assign result_o    = res_q;
endmodule

// File: rtl/shfl_check.sv
module shfl_check #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  localparam int LIDX_W = $clog2(LANES)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid_i,
  input logic [LANES*DW-1:0] lanes_i,
  input logic [LANES-1:0]    act_mask_i,
  input logic [1:0]          op_i,
  input logic [LIDX_W-1:0]   operand_i,
  input logic                out_valid_o,
  input logic [LANES*DW-1:0] result_o
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);  // R2
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> $stable(result_o));  // R9
  AST_XOR_ZERO_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i == 2'd3 && operand_i == '0) |=> result_o == $past(lanes_i));  // R6
  AST_UP_ZERO_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i == 2'd1 && operand_i == '0) |=> result_o == $past(lanes_i));  // R4
  AST_NONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && act_mask_i == '0) |=> result_o == $past(lanes_i));  // R7
endmodule

bind warp_shuffle_unit shfl_check #(.LANES(LANES), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid_i  (in_valid_i),
  .lanes_i     (lanes_i),
  .act_mask_i  (act_mask_i),
  .op_i        (op_i),
  .operand_i   (operand_i),
  .out_valid_o (out_valid_o),
  .result_o    (result_o)
);

// File: tb/warp_shuffle_unit_tb.sv
`timescale 1ns/1ps
module warp_shuffle_unit_tb;
  localparam int N = 32;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [N*W-1:0] lanes = '0;
  logic [N-1:0]   amask = '1;
  logic [1:0]     op = 2'd0;
  logic [4:0]     opnd = 5'd0;
  logic [5:0]     wsel = 6'd32;
  logic           out_valid;
  logic [N*W-1:0] result;

  int n_chk = 0;
  int n_bad = 0;
  logic [N*W-1:0] last_exp;

  always #2.5 clk = ~clk;

  warp_shuffle_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .lanes_i(lanes),
    .act_mask_i(amask), .op_i(op), .operand_i(opnd), .width_i(wsel),
    .out_valid_o(out_valid), .result_o(result)
  );

  function automatic logic [N*W-1:0] model(input logic [N*W-1:0] d, input logic [N-1:0] m,
                                           input int o, input int k, input int ws);
    logic [N*W-1:0] r;
    int w, grp, off, s;
    bit own;
    w = (ws == 2 || ws == 4 || ws == 8 || ws == 16 || ws == 32) ? ws : 32;  // R8
    for (int i = 0; i < N; i++) begin
      grp = (i / w) * w;
      off = i % w;
      own = 0;
      s = i;
      case (o)
        0: s = grp + (k % w);                                   // R3
        1: if (off >= k) s = i - k; else own = 1;               // R4
        2: if (off + k < w) s = i + k; else own = 1;            // R5
        default: s = grp + ((off ^ k) % w);                     // R6
      endcase
      if (!own && !m[s]) own = 1;                               // R7
      r[i*W +: W] = own ? d[i*W +: W] : d[s*W +: W];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic ok, input logic [N*W-1:0] act,
                       input logic [N*W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h valid=%b expected=%h", req, act, out_valid, exp);
    end
  endtask

  function automatic logic [N*W-1:0] rand_lanes();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = $urandom;
    return v;
  endfunction

  task automatic shot(input string req, input logic [N*W-1:0] d, input logic [N-1:0] m,
                      input int o, input int k, input int ws);
    logic [N*W-1:0] e;
    lanes = d; amask = m; op = 2'(o); opnd = 5'(k); wsel = 6'(ws); in_valid = 1'b1;
    e = model(d, m, o, k, ws);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_valid === 1'b1 && result === e, result, e);  // R2 and req
    last_exp = e;
  endtask

  logic [N*W-1:0] ramp;

  initial begin
    void'($urandom(32'h1234_abcd));
    for (int i = 0; i < N; i++) ramp[i*W +: W] = 32'h100 + i;
    repeat (3) @(negedge clk);
    check("R1", out_valid === 1'b0 && result === '0, result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle", out_valid === 1'b0, result, '0);

    shot("R3 w16 src3", ramp, '1, 0, 3, 16);
    shot("R3 broadcast", ramp, '1, 0, 5, 32);
    shot("R3 src beyond width", ramp, '1, 0, 13, 4);
    shot("R4 up d1 w8", ramp, '1, 1, 1, 8);
    shot("R4 up d5 w32", ramp, '1, 1, 5, 32);
    shot("R4 up d>=w", ramp, '1, 1, 9, 8);
    shot("R5 down d3 w4", ramp, '1, 2, 3, 4);
    shot("R5 down d31 w32", ramp, '1, 2, 31, 32);
    shot("R6 xor m1", ramp, '1, 3, 1, 32);
    shot("R6 xor m16 w8", ramp, '1, 3, 16, 8);
    shot("R7 inactive src", ramp, 32'hFFFF_FFF7, 0, 3, 32);
    shot("R7 inactive xor", ramp, 32'h5555_5555, 3, 1, 2);
    shot("R8 width 3", ramp, '1, 2, 1, 3);
    shot("R8 width 0", ramp, '1, 0, 7, 0);
    shot("R8 width 63", ramp, '1, 1, 2, 63);

    // R9: idle cycles with changing inputs keep the last result
    for (int j = 0; j < 3; j++) begin
      lanes = rand_lanes(); op = 2'($urandom); opnd = 5'($urandom);
      @(negedge clk);
      check("R9 hold", out_valid === 1'b0 && result === last_exp, result, last_exp);
    end

    for (int t = 0; t < 400; t++) begin
      int ws, o, k;
      logic [N-1:0] m;
      ws = 1 << (1 + ($urandom % 5));
      if ($urandom % 8 == 0) ws = $urandom % 64;
      o = $urandom % 4;
      k = $urandom % 32;
      m = ($urandom % 3 == 0) ? N'($urandom) : '1;
      case (o)
        0: shot("R3 random", rand_lanes(), m, o, k, ws);
        1: shot("R4 random", rand_lanes(), m, o, k, ws);
        2: shot("R5 random", rand_lanes(), m, o, k, ws);
        default: shot("R6 random", rand_lanes(), m, o, k, ws);
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule